// File: doc/BRIEF.md
# SD Command Issue Unit

This unit takes a command for an SD/MMC card from a 16-bit command register and a 32-bit argument register. It presents the command to the line-level serialiser as a one-cycle issue strobe. It then waits for the card's answer and stores that answer in a 128-bit response store, read as four 32-bit words. The card side is abstracted. A response arrives as a raw bit vector qualified by a valid strobe. A no-response condition arrives as a timeout strobe. CRC and index mismatches, which are detected further down the line, arrive as two flags beside the response.

Two inhibit flags in a present-state word tell software when it may issue the next command. The CMD flag covers the command-and-response window. The DAT flag covers the busy phase of commands that signal busy on DAT0. The same word mirrors the four DAT line levels. Sticky status bits record completion, timeout and errors, and software clears them by writing ones.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A write to the command register while CMD inhibit is clear is accepted. Its fields are command index in bits [13:8], data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3 and response kind in bits [1:0]. On the cycle after the write, `issue_valid` is high for exactly one cycle, together with that index, the last written argument, the response kind and the data-present flag.
- R2: `pstate` bit 0 (CMD inhibit) is high from the cycle after an accepted write until the response or timeout is taken in. For response kind 00 (none), the command completes one cycle after the issue strobe, and status bit 0 (done) is set.
- R3: A command register write while `pstate` bit 0 is high is ignored. No further issue strobe follows it.
- R4: For kind 01 (136-bit), the store becomes `{8'h00, resp_raw[127:8]}`. The trailing CRC byte is removed and the rest is right-aligned, so word k is `rsp_o[32k+31:32k]`.
- R5: For kind 10 or 11 (48-bit), word 0 takes `resp_raw[39:8]`, and words 1 to 3 keep their previous contents.
- R6: A timeout while a response is awaited sets status bit 1 (timeout) and bit 2 (error). It does not set done, and it leaves the response store unchanged.
- R7: A CRC mismatch sets status bit 3 only when CRC checking is enabled. An index mismatch sets status bit 4 only when index checking is enabled. Either one also sets bit 2. Done is set whenever a response is taken in.
- R8: For kind 11, `pstate` bit 1 (DAT inhibit) is high from the cycle after the write. It falls one cycle after the first cycle, following the response, in which DAT0 is high. A timeout also clears it.
- R9: `pstate[23:20]` equals `dat_i` in the same cycle, and all other `pstate` bits above bit 1 are zero.
- R10: Status bits are write-one-to-clear through `sts_clr`. A bit being set in the same cycle it is cleared stays set.
- R11: After reset, the status bits, the response store, both inhibit flags and `issue_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | ARG_W | Argument write data |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command register write data |
| sts_clr | input | 5 | Write-one-to-clear mask for status bits |
| resp_valid | input | 1 | Card response present |
| resp_timeout | input | 1 | Card did not answer |
| resp_crc_bad | input | 1 | Response CRC mismatch |
| resp_idx_bad | input | 1 | Response index mismatch |
| resp_raw | input | RSP_WORDS*WORD_W+8 | Raw response bits, end at bit 0 |
| dat_i | input | 4 | DAT[3:0] line levels |
| pstate | output | 32 | Present state: inhibits and DAT levels |
| sts | output | 5 | Status: done, timeout, error, CRC, index |
| rsp_o | output | RSP_WORDS*WORD_W | Response store, word 0 lowest |
| issue_valid | output | 1 | One-cycle command issue strobe |
| issue_idx | output | 6 | Issued command index |
| issue_arg | output | ARG_W | Issued argument |
| issue_kind | output | 2 | Issued response kind |
| issue_data | output | 1 | Issued data-present flag |

## Verification
The bench attacks the CRC strip on long responses by using patterns whose bytes all differ, so an alignment off by one byte changes every word. It also checks that a short response touches word 0 only. Error masking is tested with both mismatch flags raised while only one check is enabled; a unit that ignores its enables would report the other error. A second command is written while the first is still in flight, so a design that queues or accepts it shows a second issue strobe. The busy phase is held with DAT0 low for several cycles, which exposes any release of DAT inhibit on the response itself or on a timeout path. A status clear is made to collide with a done event to test the set-wins rule.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_L136 = 2'b01,
        RSP_L48  = 2'b10,
        RSP_L48B = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [5:0] idx;
        logic       dpres;
        logic       idx_chk;
        logic       crc_chk;
        rsp_kind_e  kind;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam int STS_N    = 5;
    localparam int STS_DONE = 0;
    localparam int STS_TMO  = 1;
    localparam int STS_ERR  = 2;
    localparam int STS_CRC  = 3;
    localparam int STS_IDX  = 4;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [15:0] reg_i,
    output cmd_fields_t fld_o
);
    always_comb begin
        fld_o.idx     = reg_i[13:8];
        fld_o.dpres   = reg_i[5];
        fld_o.idx_chk = reg_i[4];
        fld_o.crc_chk = reg_i[3];
        fld_o.kind    = rsp_kind_e'(reg_i[1:0]);
    end
endmodule

// File: rtl/sdc_resp_align.sv
module sdc_resp_align
    import sdc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4
) (
    input  rsp_kind_e                     kind_i,
    input  logic [RSP_WORDS*WORD_W+7:0]   raw_i,
    input  logic [RSP_WORDS*WORD_W-1:0]   cur_i,
    output logic [RSP_WORDS*WORD_W-1:0]   nxt_o
);
    localparam int RSP_W = RSP_WORDS * WORD_W;

    logic [RSP_W-1:0] stripped;
    assign stripped = {8'h00, raw_i[RSP_W-1:8]};

    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        always_comb begin
            if (kind_i == RSP_L136) begin
                nxt_o[w*WORD_W +: WORD_W] = stripped[w*WORD_W +: WORD_W];
            end else if (w == 0) begin
                nxt_o[w*WORD_W +: WORD_W] = raw_i[WORD_W+7:8];
            end else begin
                nxt_o[w*WORD_W +: WORD_W] = cur_i[w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/sdc_sticky.sv
module sdc_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] bits_d, bits_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_comb begin
            if (set_i[b])      bits_d[b] = 1'b1;
            else if (clr_i[b]) bits_d[b] = 1'b0;
            else               bits_d[b] = bits_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arg_wr,
    input  logic [ARG_W-1:0]              arg_wdata,
    input  logic                          cmd_wr,
    input  logic [15:0]                   cmd_wdata,
    input  logic [4:0]                    sts_clr,
    input  logic                          resp_valid,
    input  logic                          resp_timeout,
    input  logic                          resp_crc_bad,
    input  logic                          resp_idx_bad,
    input  logic [RSP_WORDS*WORD_W+7:0]   resp_raw,
    input  logic [3:0]                    dat_i,
    output logic [31:0]                   pstate,
    output logic [4:0]                    sts,
    output logic [RSP_WORDS*WORD_W-1:0]   rsp_o,
    output logic                          issue_valid,
    output logic [5:0]                    issue_idx,
    output logic [ARG_W-1:0]              issue_arg,
    output logic [1:0]                    issue_kind,
    output logic                          issue_data
);
    localparam int RSP_W = RSP_WORDS * WORD_W;

    typedef struct packed {
        phase_e            phase;
        cmd_fields_t       fld;
        logic [ARG_W-1:0]  arg;
        logic [ARG_W-1:0]  arg_lat;
        logic              dat_inh;
        logic              bwait;
        logic [RSP_W-1:0]  rsp;
    } state_t;

    state_t            st_d, st_q;
    cmd_fields_t       dec_f;
    logic [RSP_W-1:0]  aligned;
    logic [STS_N-1:0]  sts_set;

    sdc_cmd_decode u_dec (
        .reg_i (cmd_wdata),
        .fld_o (dec_f)
    );

    sdc_resp_align #(
        .WORD_W    (WORD_W),
        .RSP_WORDS (RSP_WORDS)
    ) u_align (
        .kind_i (st_q.fld.kind),
        .raw_i  (resp_raw),
        .cur_i  (st_q.rsp),
        .nxt_o  (aligned)
    );

    sdc_sticky #(.N(STS_N)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sts_set),
        .clr_i (sts_clr),
        .q_o   (sts)
    );

    always_comb begin
        st_d    = st_q;
        sts_set = '0;

        if (arg_wr) st_d.arg = arg_wdata;

        // busy phase ends once DAT0 returns high after the response
        if (st_q.bwait && dat_i[0]) begin
            st_d.dat_inh = 1'b0;
            st_d.bwait   = 1'b0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_wr) begin
                    st_d.fld     = dec_f;
                    st_d.arg_lat = st_q.arg;
                    st_d.phase   = PH_ISSUE;
                    if (dec_f.kind == RSP_L48B) begin
                        st_d.dat_inh = 1'b1;
                        st_d.bwait   = 1'b0;
                    end
                end
            end
            PH_ISSUE: begin
                if (st_q.fld.kind == RSP_NONE) begin
                    sts_set[STS_DONE] = 1'b1;
                    st_d.phase        = PH_IDLE;
                end else begin
                    st_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (resp_timeout) begin
                    sts_set[STS_TMO] = 1'b1;
                    sts_set[STS_ERR] = 1'b1;
                    st_d.phase       = PH_IDLE;
                    if (st_q.fld.kind == RSP_L48B) begin
                        st_d.dat_inh = 1'b0;
                        st_d.bwait   = 1'b0;
                    end
                end else if (resp_valid) begin
                    sts_set[STS_DONE] = 1'b1;
                    if (st_q.fld.crc_chk && resp_crc_bad) begin
                        sts_set[STS_CRC] = 1'b1;
                        sts_set[STS_ERR] = 1'b1;
                    end
                    if (st_q.fld.idx_chk && resp_idx_bad) begin
                        sts_set[STS_IDX] = 1'b1;
                        sts_set[STS_ERR] = 1'b1;
                    end
                    st_d.rsp   = aligned;
                    st_d.phase = PH_IDLE;
                    if (st_q.fld.kind == RSP_L48B) st_d.bwait = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pstate      = {8'h00, dat_i, 18'h0, st_q.dat_inh, (st_q.phase != PH_IDLE)};
    assign rsp_o       = st_q.rsp;
    assign issue_valid = (st_q.phase == PH_ISSUE);
    assign issue_idx   = st_q.fld.idx;
    assign issue_arg   = st_q.arg_lat;
    assign issue_kind  = st_q.fld.kind;
    assign issue_data  = st_q.fld.dpres;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        resp_valid,
    input logic        resp_timeout,
    input logic        resp_crc_bad,
    input logic [3:0]  dat_i,
    input logic [31:0] pstate,
    input logic [4:0]  sts,
    input logic        issue_valid
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !pstate[0]) |=> (pstate[0] && issue_valid));

    assert_issue_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    assert_inhibit_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pstate[0]) |-> ($past(resp_valid) || $past(resp_timeout) || $past(issue_valid)));

    assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && pstate[0]) |=> !issue_valid);

    assert_tmo_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[1]) |-> sts[2]);

    assert_crc_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[3]) |-> ($past(resp_crc_bad) && sts[2]));

    assert_dat_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pstate[1]) |-> ($past(dat_i[0]) || $past(resp_timeout)));
endmodule

bind sd_cmd_issuer sdc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .resp_valid   (resp_valid),
    .resp_timeout (resp_timeout),
    .resp_crc_bad (resp_crc_bad),
    .dat_i        (dat_i),
    .pstate       (pstate),
    .sts          (sts),
    .issue_valid  (issue_valid)
);

// File: tb/sim_sd_cmd_issuer.sv
module sim_sd_cmd_issuer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_wdata = '0;
    logic [4:0]   sts_clr = '0;
    logic         resp_valid = 1'b0;
    logic         resp_timeout = 1'b0;
    logic         resp_crc_bad = 1'b0;
    logic         resp_idx_bad = 1'b0;
    logic [135:0] resp_raw = '0;
    logic [3:0]   dat_i = 4'hF;
    logic [31:0]  pstate;
    logic [4:0]   sts;
    logic [127:0] rsp_o;
    logic         issue_valid;
    logic [5:0]   issue_idx;
    logic [31:0]  issue_arg;
    logic [1:0]   issue_kind;
    logic         issue_data;

    int checks = 0;
    int fails  = 0;
    int n_issue = 0;
    logic [127:0] exp_rsp = '0;

    always #10 clk = ~clk;

    sd_cmd_issuer u0 (
        .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .sts_clr(sts_clr),
        .resp_valid(resp_valid), .resp_timeout(resp_timeout),
        .resp_crc_bad(resp_crc_bad), .resp_idx_bad(resp_idx_bad),
        .resp_raw(resp_raw), .dat_i(dat_i), .pstate(pstate), .sts(sts),
        .rsp_o(rsp_o), .issue_valid(issue_valid), .issue_idx(issue_idx),
        .issue_arg(issue_arg), .issue_kind(issue_kind), .issue_data(issue_data)
    );

    always @(negedge clk) if (rst_n && issue_valid) n_issue++;

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] arg;
        logic        tmo;
        logic        crc;
        logic        idxe;
        logic [4:0]  exp_sts;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'h110A, 32'h0123_4567, 1'b0, 1'b0, 1'b0, 5'h01},
        '{16'h0209, 32'h89AB_CDEF, 1'b0, 1'b0, 1'b0, 5'h01},
        '{16'h0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'h01},
        '{16'h371A, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 5'h0D},
        '{16'h0812, 32'h1357_9BDF, 1'b0, 1'b1, 1'b1, 5'h15},
        '{16'h0502, 32'h2468_ACE0, 1'b0, 1'b1, 1'b1, 5'h01},
        '{16'h2902, 32'h5555_AAAA, 1'b1, 1'b0, 1'b0, 5'h06},
        '{16'h0901, 32'h0F0F_F0F0, 1'b1, 1'b0, 1'b0, 5'h06}
    };

    function automatic logic [135:0] mk_raw(input logic [31:0] a);
        return {a ^ 32'hA5A5_A5A5, a, ~a, a[15:0], a[31:16], 8'h3C};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] c, input logic [31:0] a);
        @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk); arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic answer(input logic tmo, input logic crc, input logic ie, input logic [135:0] raw);
        resp_raw = raw; resp_valid = !tmo; resp_timeout = tmo;
        resp_crc_bad = crc; resp_idx_bad = ie;
        @(negedge clk);
        resp_valid = 1'b0; resp_timeout = 1'b0; resp_crc_bad = 1'b0; resp_idx_bad = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); sts_clr = 5'h1F;
        @(negedge clk); sts_clr = 5'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 inhibits", {126'd0, pstate[1:0]}, 128'd0);
        chk("R11 status", {123'd0, sts}, 128'd0);
        chk("R11 response", rsp_o, 128'd0);
        chk("R11 issue", {127'd0, issue_valid}, 128'd0);

        // R9 line mirror
        dat_i = 4'hA; #1;
        chk("R9 dat mirror", {96'd0, pstate}, {96'd0, 8'h00, 4'hA, 20'h0});
        dat_i = 4'hF;

        foreach (VECS[i]) begin
            vec_t v;
            logic [135:0] raw;
            logic [1:0]   k;
            v = VECS[i];
            raw = mk_raw(v.arg);
            k = v.cmd[1:0];
            clear_all();
            send(v.cmd, v.arg);
            chk("R1 issue strobe", {127'd0, issue_valid}, 128'd1);
            chk("R1 issue index", {122'd0, issue_idx}, {122'd0, v.cmd[13:8]});
            chk("R1 issue arg", {96'd0, issue_arg}, {96'd0, v.arg});
            chk("R1 issue kind", {126'd0, issue_kind}, {126'd0, k});
            @(negedge clk);
            if (k != 2'b00) answer(v.tmo, v.crc, v.idxe, raw);
            if (!v.tmo) begin
                if (k == 2'b01) exp_rsp = {8'h00, raw[127:8]};
                else if (k[1]) exp_rsp[31:0] = raw[39:8];
            end
            chk(v.tmo ? "R6 status" : (k == 2'b00 ? "R2 status" : "R7 status"),
                {123'd0, sts}, {123'd0, v.exp_sts});
            chk(k == 2'b01 ? "R4 response" : (v.tmo ? "R6 response" : "R5 response"),
                rsp_o, exp_rsp);
            chk("R2 inhibit released", {127'd0, pstate[0]}, 128'd0);
        end

        // R3: second write while in flight is ignored
        begin
            int n0;
            logic [135:0] raw;
            clear_all();
            n0 = n_issue;
            raw = mk_raw(32'hCAFE_F00D);
            send(16'h0302, 32'hCAFE_F00D);
            @(negedge clk);
            cmd_wr = 1'b1; cmd_wdata = 16'h0702;
            @(negedge clk);
            cmd_wr = 1'b0;
            chk("R3 no reissue", {127'd0, issue_valid}, 128'd0);
            chk("R3 still inhibited", {127'd0, pstate[0]}, 128'd1);
            answer(1'b0, 1'b0, 1'b0, raw);
            exp_rsp[31:0] = raw[39:8];
            @(negedge clk);
            chk("R3 single issue", 128'(n_issue - n0), 128'd1);
            chk("R3 idle after", {127'd0, pstate[0]}, 128'd0);
            chk("R5 word0 only", rsp_o, exp_rsp);
        end

        // R8: busy phase held by DAT0 low
        begin
            logic [135:0] raw;
            raw = mk_raw(32'h7777_1111);
            dat_i = 4'hE;
            send(16'h0703, 32'h7777_1111);
            chk("R8 dat inhibit set", {127'd0, pstate[1]}, 128'd1);
            @(negedge clk);
            answer(1'b0, 1'b0, 1'b0, raw);
            chk("R2 cmd inhibit clear", {127'd0, pstate[0]}, 128'd0);
            repeat (3) @(negedge clk);
            chk("R8 held while busy", {127'd0, pstate[1]}, 128'd1);
            dat_i = 4'hF;
            @(negedge clk);
            chk("R8 released on DAT0 high", {127'd0, pstate[1]}, 128'd0);
        end

        // R8: timeout clears DAT inhibit
        dat_i = 4'hE;
        send(16'h0703, 32'h1);
        @(negedge clk);
        answer(1'b1, 1'b0, 1'b0, '0);
        chk("R8 timeout release", {127'd0, pstate[1]}, 128'd0);
        dat_i = 4'hF;

        // R10: selective clear, then set wins over clear
        @(negedge clk); sts_clr = 5'h02;
        @(negedge clk); sts_clr = 5'h00;
        chk("R10 selective clear", {127'd0, sts[1]}, 128'd0);
        chk("R10 others kept", {127'd0, sts[2]}, 128'd1);
        clear_all();
        send(16'h0000, 32'h0);
        sts_clr = 5'h01;
        @(negedge clk);
        sts_clr = 5'h00;
        chk("R10 set wins", {127'd0, sts[0]}, 128'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule